// File: doc/BRIEF.md
# Clock-Loss and Frame-Mark Interrupt Controller

This block is one slice of a control register file. It watches two events: an asynchronous clock-loss level input and a one-cycle frame-mark pulse. Each event has its own sticky latch. A single arm bit per source does two jobs. When it is 0, the latch is held clear. When it is 1, the latch may set and the source may raise an interrupt. Software picks the input level that sets the clock-loss latch.

A global enable bit gates the OR of the two latches onto one interrupt pin. Software also picks the active level of that pin and whether its driver is push-pull or open-drain. Open-drain is modelled as an output-enable plus a data bit. Two bus-mode inputs decide whether the frame-mark latch can operate. A small register port gives write access to the control bits and read access to the control bits, the latch status and a fixed identification byte.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: While the loss arm bit (control bit 0) or the frame arm bit (control bit 1) is 0, the matching latch is cleared and held clear. A write that clears an arm bit wins over a set condition in the same cycle. The latch may set again on the cycle after the bit is re-armed.
- R2: `clockLossIn` passes through a two-flop synchroniser. When armed, the loss latch sets once the synchronised level equals control bit 2 (0 = sets on low, 1 = sets on high). A change at the input shows in status on the third rising edge.
- R3: A set latch stays set while its arm bit stays 1, even after the set condition goes away.
- R4: When armed and active, the frame latch sets on the edge where `framePulse` is high, and is readable on the next cycle.
- R5: The frame latch is active when `busModeSel` is 0, or when both `busModeSel` and `switchEnable` are 1. With `busModeSel`=1 and `switchEnable`=0 it is held clear and reads 0.
- R6: The interrupt condition is control bit 3 AND (loss latch OR frame latch). Bit 3 = 0 suppresses the interrupt without changing either latch status bit.
- R7: Control bit 4 selects the pin level. With 0 the pin is driven low when the interrupt condition is true. With 1 it is driven high when the condition is true.
- R8: Control bit 5 selects the driver. With 0 (open-drain), `irqOe` is 1 only while the condition is true. With 1 (push-pull), `irqOe` is always 1.
- R9: After reset, all six control bits and both latches are 0, `irqOe` is 0 and `irqOut` is 1 (inactive for active-low).
- R10: Reads are combinational from `regAddr`:
  - address 0 returns the control bits {0,0,b5..b0};
  - address 1 returns {6'b0, frame latch, loss latch};
  - address 2 returns the identification byte {version, revision}, which is 00h by default;
  - address 3 returns 0.
  A write takes effect only at address 0 when `regWrEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| clockLossIn | input | 1 | Asynchronous clock-loss level |
| framePulse | input | 1 | One-cycle frame-mark pulse, synchronous |
| busModeSel | input | 1 | Bus mode select |
| switchEnable | input | 1 | Switching enabled in the selected bus mode |
| irqOut | output | 1 | Interrupt pin data level |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
The clock-loss input is driven at both set levels. This separates a latch that compares against the level bit from one that sets on a fixed level. It also counts the three-edge synchroniser delay. Frame pulses arrive under all three bus-mode combinations, which exposes a wrong gating term. Clear writes land on cycles where the set condition is still true, which shows whether clear beats set. Each pin level is tried with each driver style, with the interrupt both enabled and masked. This tells a data-level fault apart from an output-enable fault, and shows whether the mask leaks into status.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  // Register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_IDENT = 2;

  // Control bit positions
  localparam int B_LOSS_ARM = 0;
  localparam int B_FRAME_ARM = 1;
  localparam int B_LOSS_LVL = 2;
  localparam int B_IRQ_EN = 3;
  localparam int B_ACT_HIGH = 4;
  localparam int B_PUSH_PULL = 5;
  localparam int CTRL_BITS = 6;

  typedef struct packed {
    logic lossArmNext;   // arm value in force after this edge
    logic frameArmNext;
    logic lossLevel;
    logic irqEnable;
    logic activeHigh;
    logic pushPull;
  } ctrlBus_t;
endpackage

// File: rtl/alarm_irq_regs.sv
module alarm_irq_regs
  import alarm_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [3:0] VERSION = 4'h0,
  parameter logic [3:0] REVISION = 4'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              lossStatus,
  input  logic              frameStatus,
  output ctrlBus_t          ctrl
);
  localparam logic [7:0] IDENT_BYTE = {VERSION, REVISION};

  logic [CTRL_BITS-1:0] ctrlReg;
  logic ctrlWrite;
  logic [CTRL_BITS-1:0] ctrlNext;

  assign ctrlWrite = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign ctrlNext = ctrlWrite ? regWrData[CTRL_BITS-1:0] : ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else ctrlReg <= ctrlNext;
  end

  always_comb begin
    ctrl.lossArmNext = ctrlNext[B_LOSS_ARM];
    ctrl.frameArmNext = ctrlNext[B_FRAME_ARM];
    ctrl.lossLevel = ctrlReg[B_LOSS_LVL];
    ctrl.irqEnable = ctrlReg[B_IRQ_EN];
    ctrl.activeHigh = ctrlReg[B_ACT_HIGH];
    ctrl.pushPull = ctrlReg[B_PUSH_PULL];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) regRdData[CTRL_BITS-1:0] = ctrlReg;
    else if (regAddr == ADDR_W'(ADDR_STAT)) regRdData[1:0] = {frameStatus, lossStatus};
    else if (regAddr == ADDR_W'(ADDR_IDENT)) regRdData = IDENT_BYTE;
  end

  // R10: writes to other addresses leave the control register unchanged
  assert_write_decode_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(ADDR_CTRL)) |=> $stable(ctrlReg));
endmodule

// File: rtl/alarm_irq_core.sv
module alarm_irq_core
  import alarm_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlBus_t ctrl,
  input  logic     clockLossIn,
  input  logic     framePulse,
  input  logic     busModeSel,
  input  logic     switchEnable,
  output logic     lossLatch,
  output logic     frameLatch,
  output logic     irqOut,
  output logic     irqOe
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic lossSynced;
  logic lossCond;
  logic frameActive;
  logic irqCond;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else syncChain <= clockLossIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else syncChain <= {syncChain[SYNC_STAGES-2:0], clockLossIn};
      end
    end
  endgenerate

  assign lossSynced = syncChain[SYNC_STAGES-1];
  assign lossCond = (lossSynced == ctrl.lossLevel);
  assign frameActive = !busModeSel || switchEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossLatch <= 1'b0;
      frameLatch <= 1'b0;
    end else begin
      lossLatch <= ctrl.lossArmNext && (lossLatch || lossCond);
      frameLatch <= ctrl.frameArmNext && frameActive && (frameLatch || framePulse);
    end
  end

  assign irqCond = ctrl.irqEnable && (lossLatch || frameLatch);
  assign irqOut = ctrl.activeHigh ? irqCond : !irqCond;
  assign irqOe = ctrl.pushPull || irqCond;

  assert_arm_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.lossArmNext |=> !lossLatch);
  assert_level_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.lossArmNext && lossSynced == ctrl.lossLevel) |=> lossLatch);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lossLatch && ctrl.lossArmNext) |=> lossLatch);
  assert_frame_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.frameArmNext && framePulse && !busModeSel) |=> frameLatch);
  assert_frame_forced_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busModeSel && !switchEnable) |=> !frameLatch);
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.irqEnable |-> (irqOut != ctrl.activeHigh));
  assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.pushPull && !lossLatch && !frameLatch) |-> !irqOe);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] VERSION = 4'h0,
  parameter logic [3:0] REVISION = 4'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              clockLossIn,
  input  logic              framePulse,
  input  logic              busModeSel,
  input  logic              switchEnable,
  output logic              irqOut,
  output logic              irqOe
);
  ctrlBus_t ctrl;
  logic lossLatch;
  logic frameLatch;

  alarm_irq_regs #(.ADDR_W(ADDR_W), .VERSION(VERSION), .REVISION(REVISION)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .lossStatus(lossLatch), .frameStatus(frameLatch), .ctrl(ctrl));

  alarm_irq_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .clockLossIn(clockLossIn),
    .framePulse(framePulse), .busModeSel(busModeSel), .switchEnable(switchEnable),
    .lossLatch(lossLatch), .frameLatch(frameLatch), .irqOut(irqOut), .irqOe(irqOe));
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic clockLossIn = 0;
  logic framePulse = 0;
  logic busModeSel = 0;
  logic switchEnable = 0;
  logic irqOut;
  logic irqOe;

  int tests = 0;
  int fails = 0;
  string curReq = "R9";

  // reference model state
  int mCtrl = 0;
  int mS1 = 0, mS2 = 0;
  int mLoss = 0, mFrame = 0;

  always #2 clk = ~clk;

  alarm_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .clockLossIn(clockLossIn),
    .framePulse(framePulse), .busModeSel(busModeSel), .switchEnable(switchEnable),
    .irqOut(irqOut), .irqOe(irqOe));

  task automatic check(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic modelStep();
    int nCtrl, armL, armF, active, cond;
    nCtrl = (regWrEn && regAddr == 0) ? (regWrData & 8'h3F) : mCtrl;
    armL = nCtrl & 1;
    armF = (nCtrl >> 1) & 1;
    cond = (mS2 == ((mCtrl >> 2) & 1));
    active = (!busModeSel || switchEnable);
    mLoss = armL && (mLoss || cond);
    mFrame = armF && active && (mFrame || framePulse);
    mS2 = mS1;
    mS1 = clockLossIn;
    mCtrl = nCtrl;
  endtask

  task automatic compareAll();
    int c, expOut, expOe, expRd;
    c = ((mCtrl >> 3) & 1) && (mLoss || mFrame);
    expOut = ((mCtrl >> 4) & 1) ? c : !c;
    expOe = ((mCtrl >> 5) & 1) ? 1 : c;
    case (regAddr)
      2'd0: expRd = mCtrl;
      2'd1: expRd = (mFrame << 1) | mLoss;
      default: expRd = 0;
    endcase
    check("irqOut", irqOut, expOut);
    check("irqOe", irqOe, expOe);
    check("regRdData", regRdData, expRd);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic writeCtrl(int v);
    regWrEn = 1; regAddr = 0; regWrData = 8'(v);
    tick();
    regWrEn = 0; regAddr = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    curReq = "R9";
    regAddr = 0;
    #0 compareAll();
    rstN = 1;
    idle(2);
    regAddr = 1;
    idle(1);

    // R2: high-level trigger, three-edge latency
    curReq = "R2";
    writeCtrl(8'h0D);            // arm loss, level 1, enable
    idle(3);
    clockLossIn = 1;
    idle(4);
    // R3: stays set after the input drops
    curReq = "R3";
    clockLossIn = 0;
    idle(5);
    // R1: disarm clears; rearm with low input at level 1 does not set
    curReq = "R1";
    writeCtrl(8'h0C);
    idle(2);
    writeCtrl(8'h0D);
    idle(3);
    // R2: low-level trigger
    curReq = "R2";
    writeCtrl(8'h09);
    idle(3);
    // R1: clear wins while condition persists, then sets again
    curReq = "R1";
    writeCtrl(8'h08);
    writeCtrl(8'h09);
    idle(2);
    writeCtrl(8'h00);
    // R4: frame latch
    curReq = "R4";
    clockLossIn = 1;
    writeCtrl(8'h0A);
    idle(2);
    framePulse = 1; tick(); framePulse = 0;
    idle(3);
    // R6: mask keeps status
    curReq = "R6";
    writeCtrl(8'h02);
    idle(3);
    writeCtrl(8'h0A);
    idle(1);
    // R5: forced clear mode
    curReq = "R5";
    busModeSel = 1; switchEnable = 0;
    idle(2);
    framePulse = 1; tick(); framePulse = 0;
    idle(2);
    switchEnable = 1;
    framePulse = 1; tick(); framePulse = 0;
    idle(2);
    busModeSel = 0;
    // R7 / R8: pin level and driver style
    curReq = "R7";
    writeCtrl(8'h1A);
    idle(2);
    curReq = "R8";
    writeCtrl(8'h3A);
    idle(2);
    writeCtrl(8'h18);            // active high, open-drain, no source armed
    idle(2);
    writeCtrl(8'h38);
    idle(2);
    curReq = "R7";
    writeCtrl(8'h08);            // active low, idle
    idle(2);
    // R10: identification and unused addresses, write elsewhere ignored
    curReq = "R10";
    regAddr = 2; idle(1);
    regAddr = 3; idle(1);
    regWrEn = 1; regAddr = 1; regWrData = 8'h3F; tick();
    regWrEn = 0; regAddr = 0; idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule